// File: doc/BRIEF.md
# PLL Relock and Sleep Clock Sequencer

This controller sits between software, the clock synthesizer and the clock tree. It holds one frequency-select word, which carries the loop divider's P and Q fields. It decides when the PLL may run and when the system clock is released. Software writes the word to retune the loop. The PLL then drops out of lock and settles again at the new rate. The sequencer keeps the system clock gated for the whole of that interval and reopens it only after it has seen lock fall and then rise.

Reading the word gives the stored P/Q value with one extra bit on top. That bit follows the always-running 32 kHz crystal reference through a two-flop synchronizer, so software can poll it and time its write against the reference. A sleep request turns the PLL off. After that only an interrupt or a reset turns it back on. In both cases the system clock returns only once the PLL reports lock.

Top module: `pllseq_ctrl`

## Requirements
- R1: While reset is held, and at the first edge after it, the P/Q outputs carry the DEF_P/DEF_Q parameter values, `pll_en` is 1 and `sysclk_en` is 0. Reset places the controller in the wake-up phase.
- R2: In the wake-up phase `sysclk_en` stays 0 for as long as `pll_lock` is 0. The first clock edge that samples `pll_lock` at 1 sets `sysclk_en` to 1.
- R3: `bus_rdata` bit [P_W+Q_W] equals the `ref32k` level sampled two clock edges earlier (two-flop synchronizer). Bits [P_W+Q_W-1:Q_W] hold P and bits [Q_W-1:0] hold Q.
- R4: A write (`bus_we`=1) accepted in the running phase stores `bus_wdata` bits [P_W+Q_W-1:0] into P/Q from the next edge on. The top data bit is discarded. `sysclk_en` drops to 0 at the same edge.
- R5: After an accepted write, `sysclk_en` stays 0 until `pll_lock` has been sampled at 0 and afterwards sampled at 1. It rises at the edge that samples that 1. A lock input that never falls keeps the clock gated.
- R6: A write that arrives outside the running phase (relocking, asleep or waking) leaves P/Q unchanged.
- R7: `sleep_req`=1 in the running phase sets `pll_en` and `sysclk_en` to 0 at the next edge. Both stay 0 until an interrupt arrives.
- R8: `irq`=1 while asleep sets `pll_en` to 1 at the next edge. `sysclk_en` then follows the R2 rule.
- R9: In the running phase a write takes priority over a sleep request in the same cycle. A sleep request made outside the running phase is dropped and is not remembered.
- R10: `irq` has no effect outside the sleep phase. In the running phase `sysclk_en` and `pll_en` stay 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Write strobe for the frequency-select word |
| bus_wdata | input | P_W+Q_W+1 | Write data; the top bit is discarded |
| bus_rdata | output | P_W+Q_W+1 | {synchronized reference level, P, Q} |
| ref32k | input | 1 | 32 kHz crystal reference |
| pll_lock | input | 1 | Lock indication from the PLL |
| sleep_req | input | 1 | Request to shut the PLL down |
| irq | input | 1 | Interrupt that wakes the PLL from shutdown |
| pll_en | output | 1 | PLL enable |
| pll_p | output | P_W | P divider field |
| pll_q | output | Q_W | Q divider field |
| sysclk_en | output | 1 | System clock gate enable |

## Verification
The bench builds the block with its default widths: an 11-bit P field, a 4-bit Q field and a 16-bit register word. With these widths a write can carry the discarded top bit together with distinct P and Q patterns, so a field swap or a leaked top bit shows up on the P/Q ports. The lock input is driven directly by the bench. This lets it hold lock high after a write, drop it, and raise it at chosen cycles, and so reach every phase and every same-cycle collision between write, sleep request and interrupt.

// File: rtl/pllseq_pkg.sv
package pllseq_pkg;

  typedef enum logic [2:0] {
    SQ_RUN   = 3'd0,
    SQ_LOSS  = 3'd1,
    SQ_GAIN  = 3'd2,
    SQ_SLEEP = 3'd3,
    SQ_WAKE  = 3'd4
  } seq_state_t;

  function automatic logic clk_allowed(seq_state_t s);
    return s == SQ_RUN;
  endfunction

  function automatic logic pll_allowed(seq_state_t s);
    return s != SQ_SLEEP;
  endfunction

endpackage

// File: rtl/pllseq_refsync.sv
module pllseq_refsync (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_in,
  output logic ref_q
);
  logic meta_q, stab_q;
  logic [1:0] since_rst;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      stab_q <= 1'b0;
    end else begin
      meta_q <= ref_in;
      stab_q <= meta_q;
    end
  end

  assign ref_q = stab_q;

  // Cycle count since reset, used only to open the checking window
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) since_rst <= 2'd0;
    else if (since_rst != 2'd2) since_rst <= since_rst + 2'd1;
  end

  p_ref_lag_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst == 2'd2) |-> (ref_q == $past(ref_in, 2)));

endmodule

// File: rtl/pllseq_freqreg.sv
module pllseq_freqreg #(
  parameter int P_W   = 11,
  parameter int Q_W   = 4,
  parameter int DEF_P = 24,
  parameter int DEF_Q = 6
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_ok,
  input  logic [P_W+Q_W-1:0]   wdata,
  output logic [P_W-1:0]       p_out,
  output logic [Q_W-1:0]       q_out
);
  localparam int PQ_W = P_W + Q_W;

  function automatic logic [PQ_W-1:0] pack_pq(logic [P_W-1:0] p, logic [Q_W-1:0] q);
    return {p, q};
  endfunction

  function automatic logic [P_W-1:0] field_p(logic [PQ_W-1:0] w);
    return w[PQ_W-1:Q_W];
  endfunction

  function automatic logic [Q_W-1:0] field_q(logic [PQ_W-1:0] w);
    return w[Q_W-1:0];
  endfunction

  logic [PQ_W-1:0] pq_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pq_q <= pack_pq(P_W'(DEF_P), Q_W'(DEF_Q));
    else if (wr_ok) pq_q <= wdata;
  end

  assign p_out = field_p(pq_q);
  assign q_out = field_q(pq_q);

  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_ok |=> $stable(pq_q));

  p_store_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ok |=> (p_out == field_p($past(wdata))) && (q_out == field_q($past(wdata))));

endmodule

// File: rtl/pllseq_fsm.sv
module pllseq_fsm
  import pllseq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic bus_we,
  input  logic sleep_req,
  input  logic irq,
  input  logic pll_lock,
  output logic wr_ok,
  output logic pll_en,
  output logic sysclk_en
);
  seq_state_t st, st_nx;

  always_comb begin
    st_nx = st;
    unique case (st)
      SQ_RUN:   if (bus_we) st_nx = SQ_LOSS;
                else if (sleep_req) st_nx = SQ_SLEEP;
      SQ_LOSS:  if (!pll_lock) st_nx = SQ_GAIN;
      SQ_GAIN:  if (pll_lock) st_nx = SQ_RUN;
      SQ_SLEEP: if (irq) st_nx = SQ_WAKE;
      SQ_WAKE:  if (pll_lock) st_nx = SQ_RUN;
      default:  st_nx = SQ_WAKE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st <= SQ_WAKE;
    else st <= st_nx;
  end

  assign wr_ok     = bus_we && (st == SQ_RUN);
  assign pll_en    = pll_allowed(st);
  assign sysclk_en = clk_allowed(st);

  p_clk_on_lock_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sysclk_en) |-> $past(pll_lock));

  p_gate_after_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ok |=> !sysclk_en);

  p_pll_off_by_sleep_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pll_en) |-> $past(sleep_req));

  p_pll_on_by_irq_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pll_en) |-> $past(irq));

  p_write_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ok |=> pll_en);

endmodule

// File: rtl/pllseq_ctrl.sv
module pllseq_ctrl #(
  parameter int P_W   = 11,
  parameter int Q_W   = 4,
  parameter int DEF_P = 24,
  parameter int DEF_Q = 6
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   bus_we,
  input  logic [P_W+Q_W:0]       bus_wdata,
  output logic [P_W+Q_W:0]       bus_rdata,
  input  logic                   ref32k,
  input  logic                   pll_lock,
  input  logic                   sleep_req,
  input  logic                   irq,
  output logic                   pll_en,
  output logic [P_W-1:0]         pll_p,
  output logic [Q_W-1:0]         pll_q,
  output logic                   sysclk_en
);
  localparam int PQ_W  = P_W + Q_W;
  localparam int REG_W = PQ_W + 1;

  logic wr_ok;
  logic ref_lvl;
  logic unused_wmsb;

  assign unused_wmsb = bus_wdata[REG_W-1];

  pllseq_refsync u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .ref_in (ref32k),
    .ref_q  (ref_lvl)
  );

  pllseq_fsm u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_we    (bus_we),
    .sleep_req (sleep_req),
    .irq       (irq),
    .pll_lock  (pll_lock),
    .wr_ok     (wr_ok),
    .pll_en    (pll_en),
    .sysclk_en (sysclk_en)
  );

  pllseq_freqreg #(.P_W(P_W), .Q_W(Q_W), .DEF_P(DEF_P), .DEF_Q(DEF_Q)) u_freq (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_ok (wr_ok),
    .wdata (bus_wdata[PQ_W-1:0]),
    .p_out (pll_p),
    .q_out (pll_q)
  );

  assign bus_rdata = {ref_lvl, pll_p, pll_q};

  p_sleep_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (sysclk_en && irq && !bus_we && !sleep_req) |=> sysclk_en);

endmodule

// File: tb/pllseq_ctrl_test.sv
module pllseq_ctrl_test;
  localparam int P_W = 11, Q_W = 4, DEF_P = 24, DEF_Q = 6;
  localparam int W = P_W + Q_W + 1;

  logic clk = 1'b0, rst_n = 1'b0, bus_we = 1'b0, ref32k = 1'b0;
  logic pll_lock = 1'b0, sleep_req = 1'b0, irq = 1'b0;
  logic [W-1:0] bus_wdata = '0;
  logic [W-1:0] bus_rdata;
  logic pll_en, sysclk_en;
  logic [P_W-1:0] pll_p;
  logic [Q_W-1:0] pll_q;
  int checks = 0, errors = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  pllseq_ctrl #(.P_W(P_W), .Q_W(Q_W), .DEF_P(DEF_P), .DEF_Q(DEF_Q)) uut (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .ref32k(ref32k), .pll_lock(pll_lock),
    .sleep_req(sleep_req), .irq(irq), .pll_en(pll_en), .pll_p(pll_p),
    .pll_q(pll_q), .sysclk_en(sysclk_en)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step(input int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic write_word(input logic [P_W-1:0] p, input logic [Q_W-1:0] q, input logic top);
    bus_wdata = {top, p, q};
    bus_we = 1'b1;
    step();
    bus_we = 1'b0;
  endtask

  task automatic t_reset;
    step(2);
    chk("R1 reset p", 32'(pll_p), DEF_P);
    chk("R1 reset q", 32'(pll_q), DEF_Q);
    chk("R1 reset sysclk", 32'(sysclk_en), 0);
    chk("R1 reset pll_en", 32'(pll_en), 1);
    rst_n = 1'b1;
    step();
    chk("R1 first edge sysclk", 32'(sysclk_en), 0);
    chk("R1 first edge p/q", 32'(bus_rdata[W-2:0]), (DEF_P << Q_W) | DEF_Q);
  endtask

  task automatic t_wake;
    step(3);
    chk("R2 no lock no clock", 32'(sysclk_en), 0);
    pll_lock = 1'b1;
    step();
    chk("R2 clock after lock", 32'(sysclk_en), 1);
  endtask

  task automatic t_ref;
    ref32k = 1'b1;
    step();
    chk("R3 ref after one edge", 32'(bus_rdata[W-1]), 0);
    step();
    chk("R3 ref after two edges", 32'(bus_rdata[W-1]), 1);
    ref32k = 1'b0;
    step(2);
    chk("R3 ref falls", 32'(bus_rdata[W-1]), 0);
  endtask

  task automatic t_write_relock;
    write_word(11'd20, 4'd5, 1'b1);
    chk("R4 p stored", 32'(pll_p), 20);
    chk("R4 q stored", 32'(pll_q), 5);
    chk("R4 top bit dropped", 32'(bus_rdata[W-2:0]), (20 << Q_W) | 5);
    chk("R4 clock gated", 32'(sysclk_en), 0);
    step(3);
    chk("R5 lock never fell", 32'(sysclk_en), 0);
    write_word(11'd99, 4'd9, 1'b0);
    chk("R6 write in relock p", 32'(pll_p), 20);
    chk("R6 write in relock q", 32'(pll_q), 5);
    sleep_req = 1'b1;
    step();
    sleep_req = 1'b0;
    chk("R9 sleep in relock", 32'(pll_en), 1);
    pll_lock = 1'b0;
    step(2);
    chk("R5 lock low", 32'(sysclk_en), 0);
    pll_lock = 1'b1;
    step();
    chk("R5 reacquired", 32'(sysclk_en), 1);
    chk("R9 sleep not remembered", 32'(pll_en), 1);
  endtask

  task automatic t_sleep_wake;
    sleep_req = 1'b1;
    step();
    sleep_req = 1'b0;
    pll_lock = 1'b0;
    chk("R7 pll off", 32'(pll_en), 0);
    chk("R7 clock off", 32'(sysclk_en), 0);
    write_word(11'd7, 4'd3, 1'b0);
    chk("R6 write in sleep", 32'(pll_p), 20);
    step(4);
    chk("R7 still asleep", 32'(pll_en), 0);
    irq = 1'b1;
    step();
    irq = 1'b0;
    chk("R8 pll on", 32'(pll_en), 1);
    chk("R8 clock waits", 32'(sysclk_en), 0);
    write_word(11'd7, 4'd3, 1'b0);
    chk("R6 write in wake", 32'(pll_q), 5);
    pll_lock = 1'b1;
    step();
    chk("R8 clock after lock", 32'(sysclk_en), 1);
  endtask

  task automatic t_prio;
    sleep_req = 1'b1;
    write_word(11'd300, 4'd14, 1'b0);
    sleep_req = 1'b0;
    chk("R9 write wins pll_en", 32'(pll_en), 1);
    chk("R9 write wins p", 32'(pll_p), 300);
    chk("R9 clock gated", 32'(sysclk_en), 0);
    pll_lock = 1'b0;
    step();
    pll_lock = 1'b1;
    step();
    chk("R9 back to run", 32'(sysclk_en), 1);
  endtask

  task automatic t_irq_run;
    irq = 1'b1;
    step(2);
    irq = 1'b0;
    chk("R10 irq in run clock", 32'(sysclk_en), 1);
    chk("R10 irq in run pll", 32'(pll_en), 1);
  endtask

  task automatic t_reset_again;
    rst_n = 1'b0;
    #1;
    chk("R1 reset again p", 32'(pll_p), DEF_P);
    chk("R1 reset again clock", 32'(sysclk_en), 0);
    step();
    rst_n = 1'b1;
    step();
  endtask

  initial begin
    t_reset();
    t_wake();
    t_ref();
    t_write_relock();
    t_sleep_wake();
    t_prio();
    t_irq_run();
    t_reset_again();
    if (!finished) begin
      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule